// File: doc/BRIEF.md
# Configurable Asynchronous Control Register

This block is a W-bit edge-triggered storage register. A static 3-bit mode input sets how two active-low control lines act on the register asynchronously. A control line can clear the register, preset it to all ones, or act as a load strobe that copies a separate asynchronous data word into it. Each control takes effect on the output at once, with no wait for a clock edge. While no control is active, the register takes its synchronous data word on each rising clock edge.

A forced value is also written into the stored state on every rising edge while the control is held. When the control is released, the output therefore keeps the forced value until the next rising edge loads synchronous data. In the three modes without a load strobe, a static select input picks which control line acts as the clear. In the three load modes, line 1 is always the load strobe, and line 2 supplies the clear or the preset where the mode has one. A function that the mode does not use stays inactive whatever its line does.

Top module: `areg_cfg`

## Requirements
- R1: When `rst_n` is low at a rising edge and no asynchronous control is active, the stored value becomes zero, and `q` reads zero after that edge.
- R2: When no asynchronous control is active and `rst_n` is high, `q` takes the value of `d` at each rising edge.
- R3: Mode 3'd0 (clear only): while the selected clear line is low, `q` is all zeros at once. The other line has no effect.
- R4: Mode 3'd1 (preset only): while the non-selected line is low, `q` is all ones at once. The selected line has no effect.
- R5: Mode 3'd2 (clear and preset): the selected line clears and the other line presets. When both are low, clear has priority and `q` is zero.
- R6: Mode 3'd3 (load with clear): while `ctl1_n` is low, `q` equals `adat` at once. While `ctl2_n` is low, `q` is zero, and this clear has priority over the load.
- R7: Mode 3'd4 (load with preset): while `ctl1_n` is low, `q` equals `adat`. While `ctl2_n` is low, `q` is all ones, and this preset has priority over the load.
- R8: Mode 3'd5 (load only): while `ctl1_n` is low, `q` equals `adat`. `ctl2_n` has no effect.
- R9: In modes 3'd0 to 3'd2, `clr_sel`=0 makes `ctl1_n` the clear line and `ctl2_n` the preset line. `clr_sel`=1 swaps the two lines.
- R10: Any control that is held across a rising edge leaves its forced value in the register. After the control is released, `q` keeps that value until the next rising edge.
- R11: Mode codes 3'd6 and 3'd7 behave exactly as mode 3'd0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the stored value |
| mode | input | 3 | Static control mode, codes 0 to 5 (6 and 7 behave as 0) |
| clr_sel | input | 1 | Chooses the clear line in modes 0 to 2 |
| ctl1_n | input | 1 | Active-low control line 1 (clear, preset or load strobe) |
| ctl2_n | input | 1 | Active-low control line 2 (clear or preset) |
| adat | input | W | Word copied into the register by the load strobe |
| d | input | W | Synchronous data word |
| q | output | W | Register output, including asynchronous overrides |

## Verification
The hardest case to reach is the release of a control. The output must then show the forced value for one more cycle, not the synchronous data that is waiting on `d`. The stimulus holds controls across several edges and then drops them while `d` carries a different random word. The reference model flags the first inactive cycle after an active one as a hold check. Both lines are also driven low together in every mode and with both `clr_sel` values, which exercises each priority pair and the illegal codes.

// File: rtl/areg_pkg.sv
// Package: types shared by the configurable asynchronous control register.
// Assumes mode is static while the register is in use.
package areg_pkg;

    typedef enum logic [2:0] {
        MODE_CLR    = 3'd0,
        MODE_PRE    = 3'd1,
        MODE_BOTH   = 3'd2,
        MODE_LD_CLR = 3'd3,
        MODE_LD_PRE = 3'd4,
        MODE_LD     = 3'd5
    } areg_mode_e;

    // Decoded controls, active-high inside the block.
    typedef struct packed {
        logic clr;
        logic pre;
        logic ld;
    } areg_ctl_t;

endpackage

// File: rtl/areg_decode.sv
// Module: maps the mode, the clear-line select and the two active-low
// control lines onto active-high clear, preset and load requests.
// Assumes: functions that the mode does not use are tied inactive.
// Codes above 5 decode as mode 0.
module areg_decode
    import areg_pkg::*;
(
    input  logic [2:0] mode_i,
    input  logic       clr_sel_i,
    input  logic       ctl1_n_i,
    input  logic       ctl2_n_i,
    output areg_ctl_t  ctl_o
);

    logic line1;
    logic line2;
    logic clr_src;
    logic oth_src;

    // Purpose: turn the lines active-high and pick the clear and preset sources.
    always_comb begin
        line1   = ~ctl1_n_i;
        line2   = ~ctl2_n_i;
        clr_src = clr_sel_i ? line2 : line1;
        oth_src = clr_sel_i ? line1 : line2;
    end

    // Purpose: decode the mode into the request set.
    always_comb begin
        ctl_o = '0;
        case (areg_mode_e'(mode_i))
            MODE_CLR:    ctl_o.clr = clr_src;
            MODE_PRE:    ctl_o.pre = oth_src;
            MODE_BOTH: begin
                ctl_o.clr = clr_src;
                ctl_o.pre = oth_src;
            end
            MODE_LD_CLR: begin
                ctl_o.ld  = line1;
                ctl_o.clr = line2;
            end
            MODE_LD_PRE: begin
                ctl_o.ld  = line1;
                ctl_o.pre = line2;
            end
            MODE_LD:     ctl_o.ld  = line1;
            default:     ctl_o.clr = clr_src;
        endcase
    end

endmodule

// File: rtl/areg_resolve.sv
// Module: resolves the decoded requests by priority (clear, then preset,
// then load) into one force flag and the value being forced.
// Assumes the requests are already gated by the mode.
module areg_resolve
    import areg_pkg::*;
#(
    parameter int W = 8
) (
    input  areg_ctl_t      ctl_i,
    input  logic [W-1:0]   adat_i,
    output logic           frc_o,
    output logic [W-1:0]   fval_o
);

    // Purpose: priority selection of the forced value.
    always_comb begin
        frc_o  = ctl_i.clr | ctl_i.pre | ctl_i.ld;
        fval_o = '0;
        if (ctl_i.clr)      fval_o = '0;
        else if (ctl_i.pre) fval_o = '1;
        else if (ctl_i.ld)  fval_o = adat_i;
    end

endmodule

// File: rtl/areg_store.sv
// Module: storage bits with an output overlay. A forced value shows on the
// output at once and is written into the stored state on each rising edge
// while it lasts. Otherwise the synchronous reset or the data is captured.
// Assumes the force is held across at least one edge to be retained.
module areg_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frc_i,
    input  logic [W-1:0] fval_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] q_reg;

    // Purpose: capture the forced value, the reset value or the data.
    always_ff @(posedge clk) begin
        if (frc_i)       q_reg <= fval_i;
        else if (!rst_n) q_reg <= '0;
        else             q_reg <= d_i;
    end

    // Purpose: let an asynchronous control override the stored value.
    always_comb begin
        q_o = frc_i ? fval_i : q_reg;
    end

    // R10: after a release, the output keeps the value forced at the last edge.
    assert_hold_after_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frc_i) && !frc_i) |-> (q_o == $past(fval_i)));

    // R2: with no control active, the output follows the data of the last edge.
    assert_sync_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!frc_i) && $past(rst_n) && !frc_i) |-> (q_o == $past(d_i)));

endmodule

// File: rtl/areg_cfg.sv
// Top: a W-bit register with mode-selected asynchronous clear, preset and
// load. Assumes mode and clr_sel are static. The controls are active-low.
module areg_cfg
    import areg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   mode,
    input  logic         clr_sel,
    input  logic         ctl1_n,
    input  logic         ctl2_n,
    input  logic [W-1:0] adat,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    localparam logic [2:0] LAST_LEGAL = 3'(MODE_LD);

    areg_ctl_t    ctl;
    logic         frc;
    logic [W-1:0] fval;

    areg_decode u_decode (
        .mode_i    (mode),
        .clr_sel_i (clr_sel),
        .ctl1_n_i  (ctl1_n),
        .ctl2_n_i  (ctl2_n),
        .ctl_o     (ctl)
    );

    areg_resolve #(.W(W)) u_resolve (
        .ctl_i  (ctl),
        .adat_i (adat),
        .frc_o  (frc),
        .fval_o (fval)
    );

    areg_store #(.W(W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .frc_i  (frc),
        .fval_i (fval),
        .d_i    (d),
        .q_o    (q)
    );

    // R3: an active clear drives the output to zero.
    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.clr |-> (q == '0));

    // R4: an active preset without a clear drives the output to all ones.
    assert_preset_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.pre && !ctl.clr) |-> (q == '1));

    // R6: a load with no clear or preset shows the asynchronous data.
    assert_load_copies_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ld && !ctl.clr && !ctl.pre) |-> (q == adat));

    // R11: illegal codes never raise a load or a preset.
    assert_illegal_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode > LAST_LEGAL) |-> (!ctl.ld && !ctl.pre));

endmodule

// File: tb/areg_cfg_bench.sv
// Bench: a behavioural reference model updated every clock and compared
// with the output in every cycle.
module areg_cfg_bench;

    localparam int W = 8;

    logic         clk;
    logic         rst_n;
    logic [2:0]   mode;
    logic         clr_sel;
    logic         ctl1_n;
    logic         ctl2_n;
    logic [W-1:0] adat;
    logic [W-1:0] d;
    logic [W-1:0] q;

    int checks;
    int errors;
    logic [W-1:0] mstate;
    bit           mknown;
    bit           prev_act;

    areg_cfg #(.W(W)) u_areg_cfg (
        .clk(clk), .rst_n(rst_n), .mode(mode), .clr_sel(clr_sel),
        .ctl1_n(ctl1_n), .ctl2_n(ctl2_n), .adat(adat), .d(d), .q(q)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Reference: gives whether a control is active and the value it forces.
    function automatic void model_force(input logic [2:0] m, input logic s,
            input logic c1, input logic c2, input logic [W-1:0] a,
            output bit act, output logic [W-1:0] v);
        int  lm;
        bit  cl, pr, ld, l1, l2;
        lm = (m > 3'd5) ? 0 : int'(m);
        l1 = !c1;
        l2 = !c2;
        if (lm <= 2) begin
            cl = (lm != 1) && (s ? l2 : l1);
            pr = (lm != 0) && (s ? l1 : l2);
            ld = 0;
        end else begin
            ld = l1;
            cl = (lm == 3) && l2;
            pr = (lm == 4) && l2;
        end
        act = cl || pr || ld;
        v   = cl ? '0 : (pr ? '1 : (ld ? a : '0));
    endfunction

    task automatic step(input string tag, input logic [2:0] m, input logic s,
            input logic c1, input logic c2, input logic [W-1:0] a,
            input logic [W-1:0] dv, input logic r);
        bit           act;
        logic [W-1:0] v;
        logic [W-1:0] exp;
        string        t;
        @(negedge clk);
        mode = m; clr_sel = s; ctl1_n = c1; ctl2_n = c2; adat = a; d = dv; rst_n = r;
        #1;
        model_force(m, s, c1, c2, a, act, v);
        t = (prev_act && !act) ? "R10" : tag;
        if (act || mknown) begin
            exp = act ? v : mstate;
            checks++;
            if (q !== exp) begin
                errors++;
                $display("FAIL %s: q=%h expected %h (mode=%0d sel=%0d c1=%0d c2=%0d)",
                         t, q, exp, m, s, c1, c2);
            end
        end
        @(posedge clk);
        if (act)      mstate = v;
        else if (!r)  mstate = '0;
        else          mstate = dv;
        mknown   = 1;
        prev_act = act;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: cycles=%0d expected below %0d", 100000, 100000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string tags [8] = '{"R3", "R4", "R5", "R6", "R7", "R8", "R11", "R11"};
        checks = 0; errors = 0; mknown = 0; prev_act = 0; mstate = '0;
        rst_n = 1'b0; mode = 3'd0; clr_sel = 1'b0; ctl1_n = 1'b1; ctl2_n = 1'b1;
        adat = '0; d = '0;
        // R1: reset clears the stored value.
        step("R1", 3'd0, 0, 1, 1, 8'h3C, 8'hA5, 0);
        step("R1", 3'd0, 0, 1, 1, 8'h3C, 8'hA5, 0);
        step("R1", 3'd0, 0, 1, 1, 8'h3C, 8'h5A, 1);
        // R2: synchronous capture with every control idle.
        for (int i = 0; i < 8; i++)
            step("R2", 3'(i % 8), 1'(i % 2), 1, 1, 8'($urandom), 8'($urandom), 1);
        // Directed priority corners: both lines low.
        step("R5", 3'd2, 0, 0, 0, 8'h77, 8'h11, 1);
        step("R5", 3'd2, 1, 0, 0, 8'h77, 8'h22, 1);
        step("R6", 3'd3, 0, 0, 0, 8'h77, 8'h33, 1);
        step("R7", 3'd4, 0, 0, 0, 8'h77, 8'h44, 1);
        step("R8", 3'd5, 0, 1, 0, 8'h77, 8'h55, 1);
        step("R8", 3'd5, 0, 1, 0, 8'h77, 8'h66, 1);
        // R10: hold across edges, then release with new data waiting.
        step("R6", 3'd3, 0, 0, 1, 8'hC3, 8'h01, 1);
        step("R6", 3'd3, 0, 0, 1, 8'hC3, 8'h02, 1);
        step("R10", 3'd3, 0, 1, 1, 8'h00, 8'h9E, 1);
        step("R2", 3'd3, 0, 1, 1, 8'h00, 8'h9F, 1);
        // Random sweep over every code and both select values.
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < 14; k++) begin
                    string tg;
                    tg = (s == 1 && m <= 2) ? "R9" : tags[m];
                    step(tg, 3'(m), 1'(s), ($urandom % 3) != 0, ($urandom % 3) != 0,
                         8'($urandom), 8'($urandom), 1);
                end
            end
        end
        step("R2", 3'd0, 0, 1, 1, 8'h00, 8'hE7, 1);
        step("R2", 3'd0, 0, 1, 1, 8'h00, 8'h18, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule